// File: doc/BRIEF.md
# Write-Status Polling Responder

This block stands in for the internal write engine of a word-wide nonvolatile array. A decoder ahead of it hands over one request at a time: a word program (address and data) or an erase covering a sector, a block or the whole array. From the clock edge that accepts the request, the block reports busy. It waits a per-operation number of clock ticks, then updates the array through a single memory port. A program writes one word. An erase writes all ones across its range, one word per cycle.

While busy, a read does not return array contents. It returns a status word. The polling bit (bit 7) tells a program from an erase. The toggle bit (bit 6) alternates on every read. All other bits read as zero. When busy drops, reads return the array again, so software that polls the status word can tell when the write has finished. Requests that arrive while busy are dropped.

Top module: `write_status_responder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy`, `memWe` and `rdData` are all zero.
- R2: When not busy, `rdEn` with `rdAddr` loads `rdData` on the next clock edge with the word stored at `rdAddr`. `rdData` holds its value in cycles without `rdEn`.
- R3: A request accepted while idle raises `busy` on the next edge and keeps it high for exactly T+N cycles. `cmdOp` encodes the operation: 0 program (T=PROG_TICKS, N=1), 1 sector (T=SECTOR_TICKS, N=2^SECTOR_W), 2 block (T=BLOCK_TICKS, N=2^BLOCK_W), 3 whole array (T=CHIP_TICKS, N=2^ADDR_W).
- R4: A read made while a program is busy returns bit 7 equal to the inverse of bit 7 of the data being programmed. All bits other than 7 and 6 are zero.
- R5: A read made while any erase is busy returns bit 7 equal to 0. All bits other than 7 and 6 are zero.
- R6: Bit 6 of busy reads is 0 on the first read after a request is accepted and inverts on each later busy read of the same operation. Cycles without a read leave it unchanged.
- R7: When a program completes, the stored word becomes the bitwise AND of its old value and the programmed data.
- R8: When an erase completes, every word whose address matches `cmdAddr` in all bits above the range width reads all ones. Words outside the range are unchanged.
- R9: A request presented while busy is ignored. It changes neither the busy length nor the array.
- R10: The first read after busy falls returns the updated array word, with true bit 7 and a bit 6 that no longer alternates.
- R11: `memWe` is asserted only in cycles where `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Request strobe, taken only while idle |
| cmdOp | input | 2 | Operation: 0 program, 1 sector, 2 block, 3 whole array |
| cmdAddr | input | ADDR_W | Word address; selects the range for erases |
| cmdData | input | DATA_W | Program data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Registered read result or status word |
| busy | output | 1 | Operation in progress |
| memAddr | output | ADDR_W | Memory port address |
| memWe | output | 1 | Memory port write enable |
| memWdata | output | DATA_W | Memory port write data |
| memRdata | input | DATA_W | Memory port read data, combinational on memAddr |

## Verification
The bench builds the block with an 8-bit address, 4-word sectors, 16-word blocks and tick counts of 5, 9, 12 and 20. With these values the whole-array erase sweeps all 256 words in under 300 cycles, so every operation kind, the range alignment and the full busy length of each can be checked against the reference model cycle by cycle. The short waits also leave room for dense polling runs, sparse polling runs and a request dropped mid-operation in the same run. This exercises both the alternating toggle and its hold across cycles without a read.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_CHIP   = 2'd3
  } wspOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchCmd;   // capture request, reset toggle, load sweep range
    logic rdStatus;   // busy read: return status, flip toggle
    logic rdArray;    // idle read: return memory word
    logic memWrite;   // sweep phase: write current pointer
  } wspStrobe_t;

  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;

endpackage

// File: rtl/wsp_ctrl.sv
module wsp_ctrl
  import wsp_pkg::*;
#(
  parameter int PROG_TICKS   = 70,
  parameter int SECTOR_TICKS = 1800,
  parameter int BLOCK_TICKS  = 1800,
  parameter int CHIP_TICKS   = 4000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  wspOp_e     cmdOp,
  input  logic       rdEn,
  input  logic       sweepLast,
  output wspStrobe_t strobe,
  output logic       busy
);

  localparam int MAX_A     = (PROG_TICKS > SECTOR_TICKS) ? PROG_TICKS : SECTOR_TICKS;
  localparam int MAX_B     = (BLOCK_TICKS > CHIP_TICKS) ? BLOCK_TICKS : CHIP_TICKS;
  localparam int MAX_TICKS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SWEEP} state_e;

  state_e           state;
  logic [CNT_W-1:0] tickCnt;

  function automatic logic [CNT_W-1:0] ticksFor(wspOp_e op);
    case (op)
      OP_PROG:   return CNT_W'(PROG_TICKS - 1);
      OP_SECTOR: return CNT_W'(SECTOR_TICKS - 1);
      OP_BLOCK:  return CNT_W'(BLOCK_TICKS - 1);
      default:   return CNT_W'(CHIP_TICKS - 1);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            state   <= ST_WAIT;
            tickCnt <= ticksFor(cmdOp);
          end
        end
        ST_WAIT: begin
          if (tickCnt == '0) state <= ST_SWEEP;
          else               tickCnt <= tickCnt - 1'b1;
        end
        ST_SWEEP: begin
          if (sweepLast) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.latchCmd = (state == ST_IDLE) && cmdValid;
    strobe.rdStatus = busy && rdEn;
    strobe.rdArray  = !busy && rdEn;
    strobe.memWrite = (state == ST_SWEEP);
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid) |=> busy); // R3

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sweepLast) |=> busy); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_W'(MAX_TICKS - 1)); // R3

endmodule

// File: rtl/wsp_datapath.sv
module wsp_datapath
  import wsp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SECTOR_W = 11,
  parameter int BLOCK_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  wspStrobe_t        strobe,
  input  logic              busy,
  input  logic              cmdValid,
  input  wspOp_e            cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              sweepLast,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  localparam logic [ADDR_W-1:0] ALL_ONES   = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SECT_MASK  = ALL_ONES >> (ADDR_W - SECTOR_W);
  localparam logic [ADDR_W-1:0] BLOCK_MASK = ALL_ONES >> (ADDR_W - BLOCK_W);

  wspOp_e            opReg;
  logic [DATA_W-1:0] dataReg;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] endPtr;
  logic              toggle;
  logic [ADDR_W-1:0] rangeMask;
  logic [DATA_W-1:0] statusWord;

  always_comb begin
    case (cmdOp)
      OP_PROG:   rangeMask = '0;
      OP_SECTOR: rangeMask = SECT_MASK;
      OP_BLOCK:  rangeMask = BLOCK_MASK;
      default:   rangeMask = ALL_ONES;
    endcase
  end

  always_comb begin
    statusWord             = '0;
    statusWord[POLL_BIT]   = (opReg == OP_PROG) ? ~dataReg[POLL_BIT] : 1'b0;
    statusWord[TOGGLE_BIT] = toggle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= OP_PROG;
      dataReg <= '0;
      ptr     <= '0;
      endPtr  <= '0;
      toggle  <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strobe.latchCmd) begin
        opReg   <= cmdOp;
        dataReg <= cmdData;
        ptr     <= cmdAddr & ~rangeMask;
        endPtr  <= cmdAddr | rangeMask;
        toggle  <= 1'b0;
      end else if (strobe.memWrite && !sweepLast) begin
        ptr <= ptr + 1'b1;
      end
      if (strobe.rdStatus) begin
        rdData <= statusWord;
        toggle <= ~toggle;
      end else if (strobe.rdArray) begin
        rdData <= memRdata;
      end
    end
  end

  assign sweepLast = (ptr == endPtr);
  assign memWe     = strobe.memWrite;
  assign memAddr   = strobe.memWrite ? ptr : rdAddr;
  assign memWdata  = (opReg == OP_PROG) ? (memRdata & dataReg) : {DATA_W{1'b1}};

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdEn_w && opReg == OP_PROG) |=> rdData[POLL_BIT] == ~$past(dataReg[POLL_BIT])); // R4

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdEn_w && opReg != OP_PROG) |=> !rdData[POLL_BIT]); // R5

  AST_TOGGLE_ALT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdEn_w && $past(busy && rdEn_w)) |=> rdData[TOGGLE_BIT] != $past(rdData[TOGGLE_BIT])); // R6

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> ($stable(opReg) && $stable(dataReg))); // R9

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R11

  logic rdEn_w;
  assign rdEn_w = strobe.rdStatus || strobe.rdArray;

endmodule

// File: rtl/write_status_responder.sv
module write_status_responder
  import wsp_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int SECTOR_W     = 11,
  parameter int BLOCK_W      = 15,
  parameter int PROG_TICKS   = 70,
  parameter int SECTOR_TICKS = 1800,
  parameter int BLOCK_TICKS  = 1800,
  parameter int CHIP_TICKS   = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  wspStrobe_t strobe;
  logic       sweepLast;
  wspOp_e     opIn;

  assign opIn = wspOp_e'(cmdOp);

  wsp_ctrl #(
    .PROG_TICKS  (PROG_TICKS),
    .SECTOR_TICKS(SECTOR_TICKS),
    .BLOCK_TICKS (BLOCK_TICKS),
    .CHIP_TICKS  (CHIP_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (opIn),
    .rdEn     (rdEn),
    .sweepLast(sweepLast),
    .strobe   (strobe),
    .busy     (busy)
  );

  wsp_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SECTOR_W(SECTOR_W),
    .BLOCK_W (BLOCK_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busy     (busy),
    .cmdValid (cmdValid),
    .cmdOp    (opIn),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .sweepLast(sweepLast),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .memRdata (memRdata)
  );

endmodule

// File: tb/tb_write_status_responder.sv
module tb_write_status_responder;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SW = 2;
  localparam int BW = 4;
  localparam int TP = 5;
  localparam int TS = 9;
  localparam int TB = 12;
  localparam int TC = 20;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cmdValid;
  logic [1:0]    cmdOp;
  logic [AW-1:0] cmdAddr;
  logic [DW-1:0] cmdData;
  logic          rdEn;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rdData;
  logic          busy;
  logic [AW-1:0] memAddr;
  logic          memWe;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata;

  always #5 clk = ~clk;

  write_status_responder #(
    .ADDR_W(AW), .DATA_W(DW), .SECTOR_W(SW), .BLOCK_W(BW),
    .PROG_TICKS(TP), .SECTOR_TICKS(TS), .BLOCK_TICKS(TB), .CHIP_TICKS(TC)
  ) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .busy(busy), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i * 16'h03F1) ^ 16'hA55A;
  endfunction

  // Array behind the memory port
  logic [DW-1:0] mem [WORDS];
  assign memRdata = mem[memAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= pat(i);
    end else if (memWe) begin
      mem[memAddr] <= memWdata;
    end
  end

  // Behavioural reference model
  logic [DW-1:0] mArr [WORDS];
  int            mLeft;
  logic [DW-1:0] mRd;
  logic          mTog;
  int            mOp;
  logic [AW-1:0] mAddr;
  logic [DW-1:0] mData;
  int            mRdTag;

  function automatic int rangeW(int op);
    case (op)
      0: return 0;
      1: return SW;
      2: return BW;
      default: return AW;
    endcase
  endfunction

  function automatic int ticksOf(int op);
    case (op)
      0: return TP;
      1: return TS;
      2: return TB;
      default: return TC;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mArr[i] = pat(i);
      mLeft = 0; mRd = '0; mTog = 1'b0; mOp = 0; mAddr = '0; mData = '0; mRdTag = 1;
    end else begin
      if (rdEn) begin
        if (mLeft > 0) begin
          mRd = '0;
          mRd[7] = (mOp == 0) ? ~mData[7] : 1'b0;
          mRd[6] = mTog;
          mTog = ~mTog;
          mRdTag = (mOp == 0) ? 4 : 5;
        end else begin
          mRd = mArr[rdAddr];
          mRdTag = 2;
        end
      end
      if (mLeft > 0) begin
        if (mLeft == 1) begin
          if (mOp == 0) mArr[mAddr] = mArr[mAddr] & mData;
          else begin
            for (int i = 0; i < WORDS; i++)
              if ((i >> rangeW(mOp)) == (int'(mAddr) >> rangeW(mOp))) mArr[i] = '1;
          end
        end
        mLeft = mLeft - 1;
      end else if (cmdValid) begin
        mOp = int'(cmdOp); mAddr = cmdAddr; mData = cmdData;
        mLeft = ticksOf(mOp) + (1 << rangeW(mOp));
        mTog = 1'b0;
      end
    end
  end

  int checks = 0;
  int errors = 0;
  logic started = 1'b0;

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (busy !== (mLeft > 0)) begin
        errors++;
        $display("FAIL R3 busy actual=%0b expected=%0b", busy, (mLeft > 0));
      end
      checks++;
      if (rdData !== mRd) begin
        errors++;
        $display("FAIL R%0d rdData actual=%h expected=%h", mRdTag, rdData, mRd);
      end
      checks++;
      if (memWe && !busy) begin // R11
        errors++;
        $display("FAIL R11 memWe actual=1 expected=0 while idle");
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic checkArr(string tag);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < WORDS; i++)
      if (mem[i] !== mArr[i]) begin bad++; if (first < 0) first = i; end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s array word %0d actual=%h expected=%h", tag, first, mem[first], mArr[first]);
    end
  endtask

  // One operation; readGap 0 means no polling, else a read every readGap cycles
  task automatic runOp(int op, logic [AW-1:0] a, logic [DW-1:0] d, int readGap, bit intrude);
    int k = 0;
    cmdValid = 1'b1; cmdOp = 2'(op); cmdAddr = a; cmdData = d;
    cyc();
    cmdValid = 1'b0;
    while (busy) begin
      rdEn = (readGap != 0) && (k % readGap == 0);
      rdAddr = a;
      if (intrude && k == 2) begin // R9: request while busy
        cmdValid = 1'b1; cmdOp = 2'd3; cmdAddr = '0;
      end else begin
        cmdValid = 1'b0;
      end
      k++;
      cyc();
    end
    cmdValid = 1'b0;
    rdEn = 1'b1; rdAddr = a; // R10: first read after completion
    cyc();
    rdEn = 1'b0;
    checks++;
    if (rdData !== mArr[a]) begin
      errors++;
      $display("FAIL R10 readback actual=%h expected=%h", rdData, mArr[a]);
    end
    cyc();
  endtask

  bit finished = 1'b0;

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = '0; cmdAddr = '0; cmdData = '0;
    rdEn = 1'b0; rdAddr = '0;
    repeat (3) cyc();
    checks++; // R1
    if (busy !== 1'b0 || rdData !== '0 || memWe !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset busy=%b rdData=%h memWe=%b expected 0 0000 0", busy, rdData, memWe);
    end
    rstN = 1'b1;
    started = 1'b1;
    cyc();
    checks++; // R1 first cycle after reset
    if (busy !== 1'b0 || rdData !== '0) begin
      errors++;
      $display("FAIL R1 after reset busy=%b rdData=%h expected 0 0000", busy, rdData);
    end
    // R2: idle reads, with a gap to see rdData hold
    for (int i = 0; i < 6; i++) begin
      rdEn = (i != 3); rdAddr = AW'(i * 37);
      cyc();
    end
    rdEn = 1'b0; cyc();
    // R4 R6 R7: program with bit7 set, polled every cycle
    runOp(0, 8'h05, 16'h0F8F, 1, 1'b0);
    checkArr("R7");
    // R4: program with bit7 clear, sparse polling (toggle hold)
    runOp(0, 8'h21, 16'hFF3C, 3, 1'b0);
    checkArr("R7");
    // R5 R8: sector erase, polled every other cycle
    runOp(1, 8'h47, 16'h0000, 2, 1'b0);
    checkArr("R8");
    // R9: request during a program is dropped
    runOp(0, 8'h90, 16'h1234, 1, 1'b1);
    checkArr("R9");
    // R8: block erase without polling, then whole-array erase
    runOp(2, 8'hB3, 16'h0000, 0, 1'b0);
    checkArr("R8");
    runOp(0, 8'h10, 16'h00FF, 1, 1'b0);
    runOp(3, 8'h66, 16'h0000, 5, 1'b0);
    checkArr("R8");
    repeat (2) cyc();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule